// File: doc/BRIEF.md
# Fine-Grained Multithreaded Issue Selector

This block picks one hardware thread context per clock from a pool of contexts and issues that thread's head instruction. Long memory latency is hidden because consecutive issue slots go to different threads. Each context keeps a small status record. A busy flag is set while one memory operation of that thread is in flight. A credit counter says how many further instructions the thread may issue before the memory result is needed.

Every issued instruction carries a compiler-supplied lookahead count. When a memory instruction issues, the count is loaded as the thread's credit and the thread is marked busy. Each later non-memory issue from that thread spends one credit. While a thread is busy, any memory instruction at its head blocks it. So does a credit of zero. A completion event tagged with the thread number clears the busy flag. Among the threads that are ready, a round-robin pointer starts its search at the thread after the last one issued. When no thread is ready, a bubble is issued. Instruction fetch, register files and the datapath lie outside this block. The fetch side presents, for each thread, a valid bit, a memory flag and a lookahead field for the thread's head instruction.

Top module: `mt_issue_sel`

## Requirements
- R1: While reset is high and in the first cycle after it, `issue_vld` is 0. Reset clears every busy flag and sets the search pointer to thread 0, so the first issue goes to the lowest-numbered ready thread.
- R2: A thread is issued only if its `inst_valid` bit was 1 in the cycle the decision was made.
- R3: The search for a ready thread starts at the thread numbered one above the last issued thread and wraps from NUM_THREADS-1 to 0. With every thread ready and no memory operations, the issued thread numbers are therefore 0, 1, 2, … in order, wrapping around.
- R4: If no thread is ready in a cycle, the next cycle shows `issue_vld` = 0, and the search pointer keeps its value.
- R5: After a memory instruction (`inst_mem` bit = 1) with lookahead L issues, its thread can issue exactly L more non-memory instructions. It is then blocked until a completion arrives.
- R6: A thread with a memory operation in flight is blocked whenever its head instruction is a memory instruction, whatever credit it has left.
- R7: A completion with `cmp_vld` = 1 and `cmp_tid` = t clears thread t's busy flag. The thread takes part in selection from the following cycle onward.
- R8: A completion naming a thread that has no memory operation in flight has no effect on any thread.
- R9: The outputs are registered. A decision made from the inputs of cycle t appears on `issue_vld`/`issue_tid` after the clock edge that ends cycle t, and changing the inputs does not alter the outputs within a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | NUM_THREADS | Per-thread head-instruction present |
| inst_mem | input | NUM_THREADS | Per-thread head instruction is a memory operation |
| inst_la | input | NUM_THREADS*LA_W | Per-thread lookahead count; thread i in bits [i*LA_W +: LA_W] |
| cmp_vld | input | 1 | Memory completion strobe |
| cmp_tid | input | $clog2(NUM_THREADS) | Thread number of the completion |
| issue_vld | output | 1 | Issue strobe; 0 means a bubble |
| issue_tid | output | $clog2(NUM_THREADS) | Thread issued; holds its value during a bubble |

## Verification
A corrupted busy flag or credit counter shows up as an issue sequence that departs from the expected one. A thread may issue too early after a memory operation, or may stay locked out after its completion. The bench compares the issued thread against an arithmetic prediction every cycle, so such a fault shows within one cycle of the first affected decision. A wrong round-robin pointer shows up as a skipped or repeated thread. This is visible on the next issue when all threads are ready, and over sweeps of every valid pattern of a four-thread configuration.

// File: rtl/mtis_pkg.sv
package mtis_pkg;

  // A context is held back when a memory result is outstanding and either
  // its credit is spent or it would start a second memory operation.
  function automatic logic ctx_blocked(input logic busy,
                                       input logic credit_zero,
                                       input logic head_mem);
    return busy && (credit_zero || head_mem);
  endfunction

endpackage

// File: rtl/mt_thread_ctx.sv
module mt_thread_ctx #(
  parameter int LA_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            head_valid,
  input  logic            head_mem,
  input  logic [LA_W-1:0] head_la,
  input  logic            take,
  input  logic            done,
  output logic            ready
);

  logic            busy;
  logic [LA_W-1:0] credit;

  assign ready = head_valid && !mtis_pkg::ctx_blocked(busy, credit == '0, head_mem);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      credit <= '0;
    end else if (take && head_mem) begin
      busy   <= 1'b1;
      credit <= head_la;
    end else begin
      if (done) busy <= 1'b0;
      if (take && busy) credit <= credit - 1'b1;
    end
  end

endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
  parameter int N = 128,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] base,
  output logic         gnt_vld,
  output logic [W-1:0] gnt_idx
);

  always_comb begin
    logic [W-1:0] idx;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      idx = base + W'(i);
      if (!gnt_vld && req[idx]) begin
        gnt_vld = 1'b1;
        gnt_idx = idx;
      end
    end
  end

endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel #(
  parameter int NUM_THREADS = 128,
  parameter int LA_W        = 3,
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_THREADS-1:0]      inst_valid,
  input  logic [NUM_THREADS-1:0]      inst_mem,
  input  logic [NUM_THREADS*LA_W-1:0] inst_la,
  input  logic                        cmp_vld,
  input  logic [TID_W-1:0]            cmp_tid,
  output logic                        issue_vld,
  output logic [TID_W-1:0]            issue_tid
);

  logic [NUM_THREADS-1:0] ready;
  logic [TID_W-1:0]       rr_ptr;
  logic                   pick_vld;
  logic [TID_W-1:0]       pick_tid;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_ctx
    mt_thread_ctx #(.LA_W(LA_W)) u_ctx (
      .clk        (clk),
      .rst        (rst),
      .head_valid (inst_valid[g]),
      .head_mem   (inst_mem[g]),
      .head_la    (inst_la[g*LA_W +: LA_W]),
      .take       (pick_vld && (pick_tid == TID_W'(g))),
      .done       (cmp_vld && (cmp_tid == TID_W'(g))),
      .ready      (ready[g])
    );
  end

  mt_rr_pick #(.N(NUM_THREADS)) u_pick (
    .req     (ready),
    .base    (rr_ptr),
    .gnt_vld (pick_vld),
    .gnt_idx (pick_tid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr    <= '0;
      issue_vld <= 1'b0;
      issue_tid <= '0;
    end else begin
      issue_vld <= pick_vld;
      if (pick_vld) begin
        issue_tid <= pick_tid;
        rr_ptr    <= pick_tid + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mt_issue_sel_chk.sv
module mt_issue_sel_chk #(
  parameter int NUM_THREADS = 128,
  parameter int LA_W        = 3,
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_THREADS-1:0] inst_valid,
  input logic [NUM_THREADS-1:0] inst_mem,
  input logic                   cmp_vld,
  input logic [TID_W-1:0]       cmp_tid,
  input logic                   issue_vld,
  input logic [TID_W-1:0]       issue_tid
);

  logic [NUM_THREADS-1:0] valid_q;
  logic [NUM_THREADS-1:0] mem_q;
  logic [NUM_THREADS-1:0] flight;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      mem_q   <= '0;
      flight  <= '0;
    end else begin
      valid_q <= inst_valid;
      mem_q   <= inst_mem;
      for (int i = 0; i < NUM_THREADS; i++) begin
        if (cmp_vld && cmp_tid == TID_W'(i))
          flight[i] <= 1'b0;
        else if (issue_vld && mem_q[issue_tid] && issue_tid == TID_W'(i))
          flight[i] <= 1'b1;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !issue_vld); // R1

  AST_ISSUE_HAD_VALID: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> valid_q[issue_tid]); // R2

  AST_BUBBLE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (valid_q == '0) |-> !issue_vld); // R4

  AST_ONE_MEM_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && mem_q[issue_tid]) |-> !flight[issue_tid]); // R6

endmodule

bind mt_issue_sel mt_issue_sel_chk #(.NUM_THREADS(NUM_THREADS), .LA_W(LA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inst_valid (inst_valid),
  .inst_mem   (inst_mem),
  .cmp_vld    (cmp_vld),
  .cmp_tid    (cmp_tid),
  .issue_vld  (issue_vld),
  .issue_tid  (issue_tid)
);

// File: tb/tb_mt_issue_sel.sv
module tb_mt_issue_sel;
  localparam int N    = 4;
  localparam int LA_W = 2;
  localparam int TW   = $clog2(N);

  logic              clk = 1'b0;
  logic              rst;
  logic [N-1:0]      valid, mem;
  logic [N*LA_W-1:0] la;
  logic              cmp_vld;
  logic [TW-1:0]     cmp_tid;
  logic              issue_vld;
  logic [TW-1:0]     issue_tid;

  int n_chk = 0, n_err = 0, n_iss = 0;
  bit m_busy [N];
  int m_cred [N];
  int m_ptr;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  mt_issue_sel #(.NUM_THREADS(N), .LA_W(LA_W)) dut (
    .clk(clk), .rst(rst), .inst_valid(valid), .inst_mem(mem), .inst_la(la),
    .cmp_vld(cmp_vld), .cmp_tid(cmp_tid), .issue_vld(issue_vld), .issue_tid(issue_tid));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int la_of(input int t);
    return int'(la[t*LA_W +: LA_W]);
  endfunction

  task automatic step(input string tag);
    bit ev = 0; int et = 0; bit ob;
    for (int i = 0; i < N; i++) begin
      int idx = (m_ptr + i) % N;
      bit rdy = valid[idx] && !(m_busy[idx] && (m_cred[idx] == 0 || mem[idx]));
      if (!ev && rdy) begin ev = 1; et = idx; end
    end
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (issue_vld !== ev || (ev && int'(issue_tid) != et)) begin
      n_err++;
      $display("FAIL %s: vld/tid %0b/%0d expected %0b/%0d", tag, issue_vld, issue_tid, ev, et);
    end
    if (ev) begin
      ob = m_busy[et];
      if (cmp_vld && m_busy[cmp_tid]) m_busy[cmp_tid] = 0;
      if (mem[et]) begin m_busy[et] = 1; m_cred[et] = la_of(et); end
      else if (ob) m_cred[et]--;
      m_ptr = (et + 1) % N;
      n_iss++;
    end else if (cmp_vld) m_busy[cmp_tid] = 0;
  endtask

  task automatic complete(input int t, input string tag);
    cmp_vld = 1; cmp_tid = TW'(t);
    step(tag);
    cmp_vld = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int cnt, hold;
    rst = 1; valid = '1; mem = '0; la = '0; cmp_vld = 0; cmp_tid = '0;
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_cred[i] = 0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    check("R1 quiet in reset", int'(issue_vld), 0);
    rst = 0;
    check("R1 quiet after reset", int'(issue_vld), 0);
    step("R1 first issue");
    check("R1 first thread is 0", int'(issue_tid), 0);

    // R3: all ready, plain instructions: strict rotation
    for (int k = 1; k < 2 * N + 1; k++) begin
      step("R3 rotation");
      check("R3 rotation order", int'(issue_tid), k % N);
    end

    // R9: outputs do not follow inputs within a cycle
    hold = int'(issue_tid);
    valid = '0; #1;
    check("R9 registered tid", int'(issue_tid), hold);
    check("R9 registered vld", int'(issue_vld), 1);

    // R2 R4: every valid pattern
    for (int p = 0; p < (1 << N); p++) begin
      valid = N'(p);
      repeat (5) step("R2 R4 pattern sweep");
    end

    // R5 R7: lookahead credit on a lone thread
    for (int L = 0; L < (1 << LA_W); L++) begin
      valid = N'(1); mem = N'(1); la = '0; la[0 +: LA_W] = LA_W'(L);
      step("R5 mem issue");
      mem = '0; cnt = 0;
      for (int c = 0; c < (1 << LA_W) + 2; c++) begin
        step("R5 credit spend");
        if (issue_vld) cnt++;
      end
      check("R5 issues after mem op", cnt, L);
      complete(0, "R7 completion cycle");
      step("R7 resume");
      check("R7 thread resumes", int'(issue_vld), 1);
    end

    // R6: second memory op blocked despite credit
    valid = N'(1); mem = N'(1); la = '1;
    step("R6 first mem");
    cnt = 0;
    for (int c = 0; c < 4; c++) begin step("R6 blocked"); if (issue_vld) cnt++; end
    check("R6 no second mem op", cnt, 0);
    complete(0, "R6 release");
    step("R6 after release");

    // R8: stray completion leaves the blocked thread blocked
    mem = '0; step("R8 drain"); complete(0, "R8 drain");
    valid = N'(2); mem = N'(2); la = '0;
    step("R8 mem issue");
    complete(2, "R8 stray completion");
    step("R8 still blocked");
    check("R8 stray ignored", int'(issue_vld), 0);
    complete(1, "R8 real completion");
    step("R8 resume");
    check("R8 resume after real completion", int'(issue_vld), 1);

    // Mixed traffic
    for (int c = 0; c < 3000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      valid = lf[3:0] | lf[7:4];
      mem = lf[11:8] & lf[15:12];
      la = lf[7:0];
      if (lf[2]) begin
        int t = int'(lf[9:8]);
        if (m_busy[t] || lf[5]) begin cmp_vld = 1; cmp_tid = TW'(t); end
      end
      step("R3 R5 R6 R7 mixed traffic");
      cmp_vld = 0;
    end
    check("R2 mixed traffic issued something", int'(n_iss > 1000), 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule